// File: doc/BRIEF.md
# Hardened Serial Min-Sum Check Node

This block is the check-node stage of a min-sum LDPC decoder. It works on one parity row at a time. It first reads the row's incoming edge messages one per cycle, in sign-magnitude form. While it reads them it keeps a running sign parity, the two smallest magnitudes, and the position of the smallest one. It then replays the row and produces one outgoing message per edge on consecutive cycles. The sign of each outgoing message leaves out that edge's own sign. Its magnitude is the smallest magnitude among all the other edges.

The block is built to survive upsets. The sign parity is kept in two independent accumulators that are compared at replay time. The sequencing state and edge counter are held in three copies, and a bitwise two-of-three vote decides what drives the datapath. Each copy reloads from the voted value on every cycle, so a copy that is knocked out of line rejoins the others one cycle later. When a message arrives flagged as erroneous, or the two sign accumulators disagree, every outgoing message of that row is punctured to sign 0 and magnitude 0. A one-cycle fault pulse marks the last message of a punctured row. Two test inputs let the surrounding logic or a bench inject upsets into the controller copies and into the duplicate sign path.

Top module: `hmin_check_node`

## Requirements
- R1: While reset is held and right after it is released, out_valid and row_fault are 0 and the block is idle.
- R2: A row begins when row_start is sampled high in idle. row_deg (2..MAX_DEG) is latched at that edge. The next row_deg cycles with in_valid high are accepted, and gap cycles are allowed. From the cycle after the last accepted input, out_valid is high for exactly row_deg consecutive cycles. The block is idle again afterwards.
- R3: Sign 1 means negative. The output sign for edge i equals the XOR of all accepted signs of the row, XORed with the sign of edge i.
- R4: The output magnitude for edge i equals the minimum input magnitude over all other edges of the row. Ties between equal magnitudes are included.
- R5: If in_err is high on any accepted input of a row, every output of that row has sign 0 and magnitude 0.
- R6: If upset_sign is high on an accepted input, that input's sign is flipped in the duplicate sign accumulator only. The mismatch that results punctures every output of the row to sign 0 and magnitude 0.
- R7: In any cycle, setting bit k of upset_ctl inverts the state and count written into controller copy k. With at most one bit set per cycle, the outputs are unchanged.
- R8: row_fault is high only on the last output cycle of a punctured row, and is 0 in every other cycle.
- R9: row_start is ignored while a row is in progress, and in_valid, in_err and upset_sign are ignored while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| row_start | input | 1 | Begin a row; taken only when idle |
| row_deg | input | 6 | Edge count of the row, 2..MAX_DEG |
| in_valid | input | 1 | Input message present |
| in_sign | input | 1 | Input sign, 1 = negative |
| in_mag | input | 5 | Input magnitude |
| in_err | input | 1 | Error flag carried with the input message |
| upset_ctl | input | 3 | Per-copy controller upset injection |
| upset_sign | input | 1 | Flip the input sign in the duplicate sign path |
| out_valid | output | 1 | Output message present |
| out_sign | output | 1 | Output sign |
| out_mag | output | 5 | Output magnitude |
| row_fault | output | 1 | Pulse on the last output of a punctured row |

## Verification
The assertions assume three things about the inputs. row_deg is between 2 and MAX_DEG whenever a row starts. upset_ctl has at most one bit set in any cycle. The inputs are not X while reset is released. The stimulus meets these conditions in four ways: degrees come only from the legal range, controller upsets are applied one-hot and rotate through the three copies, every input is driven to a known value from time zero, and reset is held across several edges. The expected messages are recomputed in the bench by brute force over the other edges, so tie handling and puncturing are checked against arithmetic and not against the block's own min tracking.

// File: rtl/hmin_check_node.sv
module hmin_check_node #(
  parameter int MAG_W   = 5,
  parameter int MAX_DEG = 32,
  localparam int IDX_W  = $clog2(MAX_DEG),
  localparam int DEG_W  = $clog2(MAX_DEG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_start,
  input  logic [DEG_W-1:0] row_deg,
  input  logic             in_valid,
  input  logic             in_sign,
  input  logic [MAG_W-1:0] in_mag,
  input  logic             in_err,
  input  logic [2:0]       upset_ctl,
  input  logic             upset_sign,
  output logic             out_valid,
  output logic             out_sign,
  output logic [MAG_W-1:0] out_mag,
  output logic             row_fault
);

  localparam logic [1:0] ST_IDLE = 2'd0;
  localparam logic [1:0] ST_COLL = 2'd1;
  localparam logic [1:0] ST_EMIT = 2'd2;

  logic [2:0][1:0]       st_cp;
  logic [2:0][IDX_W-1:0] cnt_cp;
  logic [1:0]            st_v;
  logic [IDX_W-1:0]      cnt_v;

  logic [DEG_W-1:0]   deg_q;
  logic [MAG_W-1:0]   min1, min2;
  logic [IDX_W-1:0]   idx1;
  logic [MAX_DEG-1:0] sgn_q;
  logic               sga, sgb, err_q;
  logic               last, accept, emit, punct;

  assign st_v  = (st_cp[0] & st_cp[1]) | (st_cp[0] & st_cp[2]) | (st_cp[1] & st_cp[2]);
  assign cnt_v = (cnt_cp[0] & cnt_cp[1]) | (cnt_cp[0] & cnt_cp[2]) | (cnt_cp[1] & cnt_cp[2]);

  assign last   = DEG_W'(cnt_v) == deg_q - DEG_W'(1);
  assign accept = (st_v == ST_COLL) && in_valid;
  assign emit   = (st_v == ST_EMIT);
  assign punct  = err_q | (sga ^ sgb);

  function automatic logic [IDX_W+1:0] ctl_next(input logic [1:0] s,
                                                input logic [IDX_W-1:0] c,
                                                input logic go, input logic vld,
                                                input logic lst);
    logic [1:0]       ns;
    logic [IDX_W-1:0] nc;
    ns = s;
    nc = c;
    case (s)
      ST_IDLE: if (go) begin ns = ST_COLL; nc = '0; end
      ST_COLL: if (vld) begin
        if (lst) begin ns = ST_EMIT; nc = '0; end
        else nc = c + IDX_W'(1);
      end
      ST_EMIT: if (lst) begin ns = ST_IDLE; nc = '0; end
               else nc = c + IDX_W'(1);
      default: begin ns = ST_IDLE; nc = '0; end
    endcase
    return {ns, nc};
  endfunction

  always_ff @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      if (!rst_n) begin
        st_cp[k]  <= ST_IDLE;
        cnt_cp[k] <= '0;
      end else begin
        {st_cp[k], cnt_cp[k]} <= ctl_next(st_v, cnt_v, row_start, in_valid, last)
                                 ^ {(IDX_W+2){upset_ctl[k]}};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deg_q <= DEG_W'(2);
      min1  <= '1;
      min2  <= '1;
      idx1  <= '0;
      sgn_q <= '0;
      sga   <= 1'b0;
      sgb   <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (st_v == ST_IDLE && row_start) begin
        deg_q <= row_deg;
        min1  <= '1;
        min2  <= '1;
        idx1  <= '0;
        sga   <= 1'b0;
        sgb   <= 1'b0;
        err_q <= 1'b0;
      end
      if (accept) begin
        sgn_q[cnt_v] <= in_sign;
        sga   <= sga ^ in_sign;
        sgb   <= sgb ^ in_sign ^ upset_sign;
        err_q <= err_q | in_err;
        if (in_mag < min1) begin
          min2 <= min1;
          min1 <= in_mag;
          idx1 <= cnt_v;
        end else if (in_mag < min2) begin
          min2 <= in_mag;
        end
      end
    end
  end

  assign out_valid = emit;
  assign out_sign  = emit && !punct && (sga ^ sgn_q[cnt_v]);
  assign out_mag   = (emit && !punct) ? ((cnt_v == idx1) ? min2 : min1) : '0;
  assign row_fault = emit && last && punct;

  AST_COPIES_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upset_ctl) == 3'b000) |-> (st_cp[0] == st_cp[1] && st_cp[1] == st_cp[2] &&
                                      cnt_cp[0] == cnt_cp[1] && cnt_cp[1] == cnt_cp[2])); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_v != ST_IDLE) |-> (DEG_W'(cnt_v) < deg_q)); // R2
  AST_MIN_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (min1 <= min2)); // R4
  AST_FAULT_ENDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    row_fault |=> !out_valid); // R8
  AST_PUNCT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid) && $past(punct)) |-> (out_mag == '0 && !out_sign)); // R5

endmodule

// File: tb/test_hmin_check_node.sv
`timescale 1ns/1ps
module test_hmin_check_node;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       row_start = 1'b0;
  logic [5:0] row_deg = 6'd2;
  logic       in_valid = 1'b0;
  logic       in_sign = 1'b0;
  logic [4:0] in_mag = 5'd0;
  logic       in_err = 1'b0;
  logic [2:0] upset_ctl = 3'b000;
  logic       upset_sign = 1'b0;
  logic       out_valid, out_sign, row_fault;
  logic [4:0] out_mag;

  int total = 0;
  int bad = 0;
  int unsigned seed = 32'h1234_5678;
  bit s_a[32];
  int m_a[32];

  always #2.5 clk = ~clk;

  hmin_check_node i_hmin_check_node (
    .clk(clk), .rst_n(rst_n), .row_start(row_start), .row_deg(row_deg),
    .in_valid(in_valid), .in_sign(in_sign), .in_mag(in_mag), .in_err(in_err),
    .upset_ctl(upset_ctl), .upset_sign(upset_sign),
    .out_valid(out_valid), .out_sign(out_sign), .out_mag(out_mag), .row_fault(row_fault));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 16);
  endfunction

  // mode: 0 random, 1 all equal, 2 descending, 3 unique min last, 4 all zero, 5 all max
  task automatic fill(input int deg, input int mode);
    for (int i = 0; i < deg; i++) begin
      s_a[i] = next_rand() % 2 == 1;
      case (mode)
        1: m_a[i] = 7;
        2: m_a[i] = 31 - i;
        3: m_a[i] = (i == deg - 1) ? 1 : 4 + (next_rand() % 28);
        4: m_a[i] = 0;
        5: m_a[i] = 31;
        default: m_a[i] = next_rand() % 32;
      endcase
    end
  endtask

  task automatic run_row(input int deg, input int err_at, input int sup_at,
                         input bit gaps, input bit ctl_up, input bit hold_start);
    bit tot;
    bit fault;
    int em;
    tot = 1'b0;
    for (int i = 0; i < deg; i++) tot ^= s_a[i];
    fault = (err_at >= 0) || (sup_at >= 0);
    @(negedge clk);
    row_start = 1'b1;
    row_deg = 6'(deg);
    @(posedge clk);
    @(negedge clk);
    row_start = hold_start;
    for (int i = 0; i < deg; i++) begin
      if (gaps && (i % 3 == 1)) begin
        in_valid = 1'b0;
        in_err = 1'b1;
        upset_ctl = ctl_up ? 3'b010 : 3'b000;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R2 gap", int'(out_valid), 0);
      end
      in_valid = 1'b1;
      in_sign = s_a[i];
      in_mag = 5'(m_a[i]);
      in_err = (i == err_at);
      upset_sign = (i == sup_at);
      upset_ctl = ctl_up ? 3'(1 << (i % 3)) : 3'b000;
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_err = 1'b0;
    upset_sign = 1'b0;
    for (int i = 0; i < deg; i++) begin
      upset_ctl = ctl_up ? 3'(1 << ((i + 1) % 3)) : 3'b000;
      em = 99;
      for (int j = 0; j < deg; j++) if (j != i && m_a[j] < em) em = m_a[j];
      check(out_valid == 1'b1, "R2 emit", int'(out_valid), 1);
      if (fault) begin
        check(out_mag == 5'd0 && out_sign == 1'b0, err_at >= 0 ? "R5 punct" : "R6 punct",
              int'(out_mag) + 32 * int'(out_sign), 0);
      end else begin
        check(out_sign == (tot ^ s_a[i]), "R3 sign", int'(out_sign), int'(tot ^ s_a[i]));
        check(int'(out_mag) == em, ctl_up ? "R7 mag" : "R4 mag", int'(out_mag), em);
      end
      check(row_fault == (fault && i == deg - 1), "R8 fault", int'(row_fault),
            int'(fault && i == deg - 1));
      if (i == deg - 1) row_start = 1'b0;
      @(posedge clk);
      @(negedge clk);
    end
    upset_ctl = 3'b000;
    check(out_valid == 1'b0, "R2 end", int'(out_valid), 0);
    check(row_fault == 1'b0, "R8 after", int'(row_fault), 0);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0 && row_fault == 1'b0, "R1 in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0 && row_fault == 1'b0, "R1 after reset", int'(out_valid), 0);

    // R9: traffic while idle must not disturb the next row
    in_valid = 1'b1; in_err = 1'b1; upset_sign = 1'b1; in_mag = 5'd0; in_sign = 1'b1;
    repeat (4) begin
      @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R9 idle", int'(out_valid), 0);
    end
    in_valid = 1'b0; in_err = 1'b0; upset_sign = 1'b0;
    fill(6, 0);
    run_row(6, -1, -1, 1'b0, 1'b0, 1'b0);

    for (int d = 2; d <= 32; d++) begin
      for (int mode = 0; mode < 6; mode++) begin
        fill(d, mode);
        run_row(d, -1, -1, (d % 2) == 1, 1'b0, 1'b0);
      end
      fill(d, 0);
      run_row(d, -1, -1, 1'b0, 1'b1, 1'b0);
      fill(d, 3);
      run_row(d, -1, -1, 1'b1, 1'b1, 1'b0);
    end

    fill(8, 0); run_row(8, 0, -1, 1'b0, 1'b0, 1'b0);
    fill(8, 0); run_row(8, 7, -1, 1'b1, 1'b0, 1'b0);
    fill(32, 0); run_row(32, 15, -1, 1'b0, 1'b1, 1'b0);
    fill(5, 0); run_row(5, -1, 0, 1'b0, 1'b0, 1'b0);
    fill(5, 0); run_row(5, -1, 4, 1'b0, 1'b1, 1'b0);
    fill(2, 0); run_row(2, -1, 1, 1'b1, 1'b0, 1'b0);
    fill(9, 0); run_row(9, -1, -1, 1'b0, 1'b0, 1'b1);
    fill(3, 2); run_row(3, -1, -1, 1'b1, 1'b0, 1'b1);
    fill(7, 0); run_row(7, -1, -1, 1'b0, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule